// File: doc/BRIEF.md
# Program Counter Next-Address Unit

This block holds the program counter of a 32-bit load/store processor with fixed-size, word-aligned instructions, and chooses the address to fetch next. Each cycle it looks at the instruction word just fetched, together with the two source-register values read for it. From the opcode and function fields it picks one of four next-address sources:

- the sequential successor;
- a PC-relative conditional branch target, taken on equal or not-equal;
- an absolute jump target inside the current 256 MB region;
- the full value of a register, for a register-indirect jump.

For jump-and-link it also presents the return address together with a write strobe meant for register 31. A stall input freezes the counter and suppresses every side effect. A register-indirect jump to an address that is not word aligned is corrected by clearing the two low bits, and is reported with a one-cycle flag.

Top module: `pcnu_top`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the PC loads `RESET_ADDR` (default 0x00000000) and `misalign` becomes 0.
- R2: An instruction whose opcode (bits 31:26) is none of 0, 2, 3, 4 or 5, when not stalled, moves the PC to PC+4 at the next edge.
- R3: Opcode 4 (branch-if-equal) compares `rs_val` with `rt_val`. If they are equal, the next PC is PC+4 plus the sign-extended bits 15:0 multiplied by 4. Otherwise the next PC is PC+4.
- R4: Opcode 5 (branch-if-not-equal) uses the same target as R3, but it is taken when `rs_val` and `rt_val` differ.
- R5: Branch offsets reach from −2^15 to 2^15−1 words relative to PC+4, and the sum wraps modulo 2^32.
- R6: Opcode 2 (jump) sets the next PC to {PC[31:28], instr[25:0], 2'b00}.
- R7: Opcode 3 (jump-and-link) uses the R6 target. In the same cycle, when not stalled, `link_we` is 1 and `link_addr` equals PC+4. For every other instruction, `link_we` is 0.
- R8: Opcode 0 with function field (bits 5:0) equal to 8 is a register-indirect jump. It sets the next PC to `rs_val` with bits 1:0 cleared.
- R9: A register-indirect jump whose `rs_val[1:0]` is non-zero raises `misalign` for exactly the cycle that follows it. An aligned one does not raise it.
- R10: While `stall` is 1, the PC keeps its value, `link_we` is 0 and `misalign` is not raised.
- R11: Opcode 0 with any function field other than 8 advances the PC to PC+4.
- R12: Bits 1:0 of `pc` are always 0 once reset has been applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| stall | input | 1 | Holds the PC and blocks link and flag side effects |
| instr | input | 32 | Instruction fetched at the current PC |
| rs_val | input | 32 | Value of the first source register |
| rt_val | input | 32 | Value of the second source register |
| pc | output | 32 | Current program counter |
| link_addr | output | 32 | Return address (PC+4) for jump-and-link |
| link_we | output | 1 | Write strobe for register 31 on jump-and-link |
| misalign | output | 1 | One-cycle flag after a corrected unaligned register jump |

## Verification
The bench builds the block with its default parameters: a 32-bit address, a 16-bit branch offset, a 26-bit jump index and a reset address of zero. This is small enough to sweep every opcode value and every function value under opcode 0. It also sweeps every one of the sixteen 256 MB regions for absolute jumps, and all four low-bit patterns of a register-jump target. The bench places the PC wherever it needs it through register-indirect jumps. This makes branch offsets at both extremes reachable, including a backward branch that wraps below address zero.

// File: rtl/pcnu_pkg.sv
`timescale 1ns/1ps
// Package: opcode and function encodings decoded by the next-address unit,
// plus the selector type that passes from the decoder to the target logic.
// Assumes the 6-bit opcode sits in instruction bits 31:26 and the 6-bit
// function field sits in bits 5:0.
package pcnu_pkg;

    localparam int OPC_W = 6;
    localparam int FUN_W = 6;

    localparam logic [OPC_W-1:0] OPC_REGOP = 6'd0;
    localparam logic [OPC_W-1:0] OPC_JABS  = 6'd2;
    localparam logic [OPC_W-1:0] OPC_JLINK = 6'd3;
    localparam logic [OPC_W-1:0] OPC_BREQ  = 6'd4;
    localparam logic [OPC_W-1:0] OPC_BRNE  = 6'd5;
    localparam logic [FUN_W-1:0] FUN_JREG  = 6'd8;

    typedef enum logic [1:0] {
        NXT_SEQ    = 2'd0,
        NXT_BRANCH = 2'd1,
        NXT_JABS   = 2'd2,
        NXT_JREG   = 2'd3
    } nxt_sel_e;

    typedef struct packed {
        nxt_sel_e sel;
        logic     link;
    } nxt_ctl_t;

endpackage

// File: rtl/pcnu_decode.sv
`timescale 1ns/1ps
// Module: pcnu_decode
// Decodes only the opcode and function fields that matter for control flow,
// and resolves branch conditions by comparing the two register operands.
// Assumes: operands have DATA_W bits; all unlisted opcodes are sequential.
module pcnu_decode
    import pcnu_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [OPC_W-1:0]  opcode,
    input  logic [FUN_W-1:0]  funct,
    input  logic [DATA_W-1:0] opa,
    input  logic [DATA_W-1:0] opb,
    output nxt_ctl_t          ctl
);

    logic [DATA_W-1:0] bit_same;
    logic              ops_equal;

    // One equality cell per operand bit.
    for (genvar i = 0; i < DATA_W; i++) begin : g_cmp
        assign bit_same[i] = ~(opa[i] ^ opb[i]);
    end

    assign ops_equal = &bit_same;

    // Map the opcode and function fields to a next-address source.
    always_comb begin
        ctl.sel  = NXT_SEQ;
        ctl.link = 1'b0;
        unique case (opcode)
            OPC_BREQ:  ctl.sel = ops_equal ? NXT_BRANCH : NXT_SEQ;
            OPC_BRNE:  ctl.sel = ops_equal ? NXT_SEQ : NXT_BRANCH;
            OPC_JABS:  ctl.sel = NXT_JABS;
            OPC_JLINK: begin
                ctl.sel  = NXT_JABS;
                ctl.link = 1'b1;
            end
            OPC_REGOP: ctl.sel = (funct == FUN_JREG) ? NXT_JREG : NXT_SEQ;
            default:   ctl.sel = NXT_SEQ;
        endcase
    end

endmodule

// File: rtl/pcnu_target.sv
`timescale 1ns/1ps
// Module: pcnu_target
// Forms the four candidate addresses and selects one of them.
// - Branch: word offset added to PC+4.
// - Absolute jump: keeps the PC region bits above the jump index.
// - Register jump: clears the low two bits of the register value.
// Assumes ADDR_W >= IMM_W + 2 and ADDR_W > TGT_W + 2.
module pcnu_target
    import pcnu_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int IMM_W  = 16,
    parameter int TGT_W  = 26
) (
    input  logic [ADDR_W-1:0] pc,
    input  nxt_sel_e          sel,
    input  logic [IMM_W-1:0]  imm,
    input  logic [TGT_W-1:0]  tgt,
    input  logic [ADDR_W-1:0] reg_addr,
    output logic [ADDR_W-1:0] nxt_pc,
    output logic [ADDR_W-1:0] seq_pc,
    output logic              bad_align
);

    localparam int WSH      = 2;
    localparam int REGION_W = ADDR_W - TGT_W - WSH;
    localparam int EXT_W    = ADDR_W - IMM_W - WSH;

    logic [ADDR_W-1:0] br_off;
    logic [ADDR_W-1:0] br_pc;
    logic [ADDR_W-1:0] abs_pc;
    logic [ADDR_W-1:0] reg_pc;

    // Sequential successor, also the base for branches and the link value.
    assign seq_pc = pc + ADDR_W'(4);

    // Sign-extend the word offset and scale it to bytes.
    assign br_off = {{EXT_W{imm[IMM_W-1]}}, imm, {WSH{1'b0}}};
    assign br_pc  = seq_pc + br_off;

    // Region bits from the current PC, word index from the instruction.
    assign abs_pc = {pc[ADDR_W-1 -: REGION_W], tgt, {WSH{1'b0}}};

    // Register target forced onto a word boundary.
    assign reg_pc = {reg_addr[ADDR_W-1:WSH], {WSH{1'b0}}};

    // Pick the next address for the selected source.
    always_comb begin
        unique case (sel)
            NXT_BRANCH: nxt_pc = br_pc;
            NXT_JABS:   nxt_pc = abs_pc;
            NXT_JREG:   nxt_pc = reg_pc;
            default:    nxt_pc = seq_pc;
        endcase
    end

    // Report a register target that needed correction.
    assign bad_align = (sel == NXT_JREG) && (|reg_addr[WSH-1:0]);

endmodule

// File: rtl/pcnu_pc_reg.sv
`timescale 1ns/1ps
// Module: pcnu_pc_reg
// Program counter register and the one-cycle misalignment flag.
// Assumes synchronous active-low reset; hold blocks both the PC update and
// the setting of the flag.
module pcnu_pc_reg #(
    parameter int              ADDR_W     = 32,
    parameter logic [ADDR_W-1:0] RESET_ADDR = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hold,
    input  logic [ADDR_W-1:0] nxt_pc,
    input  logic              flag_set,
    output logic [ADDR_W-1:0] pc,
    output logic              flag
);

    // Update the PC unless held.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc <= RESET_ADDR;
        end else if (!hold) begin
            pc <= nxt_pc;
        end
    end

    // Flag lives for one cycle after an accepted corrected jump.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag <= 1'b0;
        end else begin
            flag <= flag_set & ~hold;
        end
    end

endmodule

// File: rtl/pcnu_top.sv
`timescale 1ns/1ps
// Module: pcnu_top
// Program counter with next-address selection. It decodes branch and jump
// forms from the fetched word, computes the target and registers it.
// Assumes 32-bit instruction words: opcode in 31:26, offset in 15:0,
// jump index in 25:0, function field in 5:0.
module pcnu_top
    import pcnu_pkg::*;
#(
    parameter int              ADDR_W     = 32,
    parameter int              IMM_W      = 16,
    parameter int              TGT_W      = 26,
    parameter logic [ADDR_W-1:0] RESET_ADDR = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              stall,
    input  logic [31:0]       instr,
    input  logic [ADDR_W-1:0] rs_val,
    input  logic [ADDR_W-1:0] rt_val,
    output logic [ADDR_W-1:0] pc,
    output logic [ADDR_W-1:0] link_addr,
    output logic              link_we,
    output logic              misalign
);

    localparam int INSTR_W = 32;

    nxt_ctl_t          ctl;
    logic [ADDR_W-1:0] nxt_pc;
    logic [ADDR_W-1:0] seq_pc;
    logic              bad_align;

    pcnu_decode #(.DATA_W(ADDR_W)) u_dec (
        .opcode (instr[INSTR_W-1 -: OPC_W]),
        .funct  (instr[FUN_W-1:0]),
        .opa    (rs_val),
        .opb    (rt_val),
        .ctl    (ctl)
    );

    pcnu_target #(.ADDR_W(ADDR_W), .IMM_W(IMM_W), .TGT_W(TGT_W)) u_tgt (
        .pc        (pc),
        .sel       (ctl.sel),
        .imm       (instr[IMM_W-1:0]),
        .tgt       (instr[TGT_W-1:0]),
        .reg_addr  (rs_val),
        .nxt_pc    (nxt_pc),
        .seq_pc    (seq_pc),
        .bad_align (bad_align)
    );

    pcnu_pc_reg #(.ADDR_W(ADDR_W), .RESET_ADDR(RESET_ADDR)) u_reg (
        .clk      (clk),
        .rst_n    (rst_n),
        .hold     (stall),
        .nxt_pc   (nxt_pc),
        .flag_set (bad_align),
        .pc       (pc),
        .flag     (misalign)
    );

    // Return address and its write strobe, suppressed while stalled.
    assign link_addr = seq_pc;
    assign link_we   = ctl.link & ~stall;

endmodule

// File: rtl/pcnu_checker.sv
`timescale 1ns/1ps
// Module: pcnu_checker
// Property checks on the ports of pcnu_top (default 32-bit configuration).
// Assumes rst_n is low from time zero.
module pcnu_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        stall,
    input logic [31:0] instr,
    input logic [31:0] rs_val,
    input logic [31:0] rt_val,
    input logic [31:0] pc,
    input logic [31:0] link_addr,
    input logic        link_we,
    input logic        misalign
);

    logic [5:0] op;
    logic       is_jreg;
    logic       is_other;

    assign op       = instr[31:26];
    assign is_jreg  = (op == 6'd0) && (instr[5:0] == 6'd8);
    assign is_other = (op != 6'd0) && (op != 6'd2) && (op != 6'd3) &&
                      (op != 6'd4) && (op != 6'd5);

    AST_RESET_LOADS_ZERO: assert property (@(posedge clk)
        !rst_n |=> (pc == 32'h0) && !misalign); // R1

    AST_SEQ_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        (!stall && is_other) |=> pc == $past(pc) + 32'd4); // R2

    AST_BEQ_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        (!stall && op == 6'd4 && rs_val == rt_val) |=>
        pc == $past(pc) + 32'd4 + {{14{$past(instr[15])}}, $past(instr[15:0]), 2'b00}); // R3

    AST_JUMP_ABS: assert property (@(posedge clk) disable iff (!rst_n)
        (!stall && op == 6'd2) |=>
        pc == {$past(pc[31:28]), $past(instr[25:0]), 2'b00}); // R6

    AST_LINK_ONLY_JAL: assert property (@(posedge clk) disable iff (!rst_n)
        link_we |-> (op == 6'd3) && !stall && (link_addr == pc + 32'd4)); // R7

    AST_JREG_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        (!stall && is_jreg) |=> pc == {$past(rs_val[31:2]), 2'b00}); // R8

    AST_MISALIGN_RAISED: assert property (@(posedge clk) disable iff (!rst_n)
        (!stall && is_jreg && rs_val[1:0] != 2'b00) |=> misalign); // R9

    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> $stable(pc) && !misalign); // R10

    AST_PC_WORD_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        pc[1:0] == 2'b00); // R12

endmodule

bind pcnu_top pcnu_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .stall     (stall),
    .instr     (instr),
    .rs_val    (rs_val),
    .rt_val    (rt_val),
    .pc        (pc),
    .link_addr (link_addr),
    .link_we   (link_we),
    .misalign  (misalign)
);

// File: tb/sim_pcnu_top.sv
`timescale 1ns/1ps
// Bench: sweeps opcodes, function codes, branch offsets, jump regions and
// register-target alignments against an arithmetic model of the next PC.
module sim_pcnu_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        stall = 1'b0;
    logic [31:0] instr = '0;
    logic [31:0] rs_val = '0;
    logic [31:0] rt_val = '0;
    logic [31:0] pc;
    logic [31:0] link_addr;
    logic        link_we;
    logic        misalign;

    int          total = 0;
    int          bad = 0;
    logic [31:0] m_pc = '0;

    always #10 clk = ~clk;

    pcnu_top u0 (
        .clk(clk), .rst_n(rst_n), .stall(stall), .instr(instr),
        .rs_val(rs_val), .rt_val(rt_val), .pc(pc), .link_addr(link_addr),
        .link_we(link_we), .misalign(misalign)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] mk_i(input logic [5:0] op, input logic [15:0] imm);
        return {op, 5'd9, 5'd10, imm};
    endfunction

    function automatic logic [31:0] mk_j(input logic [5:0] op, input logic [25:0] t);
        return {op, t};
    endfunction

    function automatic logic [31:0] mk_r(input logic [5:0] fn);
        return {6'd0, 5'd9, 5'd0, 5'd0, 5'd0, fn};
    endfunction

    // Next PC worked out arithmetically from the requirements.
    function automatic logic [31:0] model_next(input logic [31:0] p, input logic [31:0] ins,
                                               input logic [31:0] a, input logic [31:0] b,
                                               input logic stl);
        int off;
        off = int'($signed(ins[15:0]));
        if (stl) return p;
        case (ins[31:26])
            6'd4: return (a == b) ? p + 32'd4 + 32'(off * 4) : p + 32'd4;
            6'd5: return (a != b) ? p + 32'd4 + 32'(off * 4) : p + 32'd4;
            6'd2, 6'd3: return {p[31:28], ins[25:0], 2'b00};
            6'd0: return (ins[5:0] == 6'd8) ? (a & 32'hFFFF_FFFC) : p + 32'd4;
            default: return p + 32'd4;
        endcase
    endfunction

    // Apply one instruction from a falling edge and check after the next rise.
    task automatic run(input logic [31:0] ins, input logic [31:0] a, input logic [31:0] b,
                       input logic stl, input string tag);
        logic [31:0] exp_pc;
        logic        exp_lw;
        logic        exp_mis;
        exp_pc  = model_next(m_pc, ins, a, b, stl);
        exp_lw  = !stl && ins[31:26] == 6'd3;
        exp_mis = !stl && ins[31:26] == 6'd0 && ins[5:0] == 6'd8 && a[1:0] != 2'b00;
        instr = ins; rs_val = a; rt_val = b; stall = stl;
        #2;
        check("R7 link_we", {31'd0, link_we}, {31'd0, exp_lw});
        if (exp_lw) check("R7 link_addr", link_addr, m_pc + 32'd4);
        @(posedge clk);
        @(negedge clk);
        check(tag, pc, exp_pc);
        check("R9 misalign", {31'd0, misalign}, {31'd0, exp_mis});
        check("R12 low bits", {30'd0, pc[1:0]}, 32'd0);
        m_pc = exp_pc;
    endtask

    task automatic set_pc(input logic [31:0] a);
        run(mk_r(6'd8), a, 32'd0, 1'b0, "R8 set");
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main
        int offs [12] = '{0, 1, 2, 3, -1, -2, -5, 100, -100, 1234, 32767, -32768};
        repeat (2) @(posedge clk);
        @(negedge clk);
        check("R1 reset pc", pc, 32'h0);
        check("R1 reset misalign", {31'd0, misalign}, 32'd0);
        rst_n = 1'b1;
        m_pc = 32'h0;

        // R2: every opcode outside the control-flow set.
        for (int op = 0; op < 64; op++) begin
            if (op > 5 || op == 1) run(mk_i(6'(op), 16'h1234), 32'd1, 32'd1, 1'b0, "R2 seq");
        end

        // R11: opcode 0 with every other function code.
        for (int fn = 0; fn < 64; fn++) begin
            if (fn != 8) run(mk_r(6'(fn)), 32'h0000_0103, 32'd0, 1'b0, "R11 regop");
        end

        // R3 and R4: offsets in both directions, taken and not taken.
        for (int k = 0; k < 12; k++) begin
            for (int eq = 0; eq < 2; eq++) begin
                set_pc(32'h0010_0000);
                run(mk_i(6'd4, 16'(offs[k])), 32'h55, eq ? 32'h55 : 32'h56, 1'b0, "R3 beq");
                set_pc(32'h0010_0000);
                run(mk_i(6'd5, 16'(offs[k])), 32'hAA, eq ? 32'hAA : 32'h0A, 1'b0, "R4 bne");
            end
        end

        // R5: extreme offsets including wrap below zero and above the top.
        set_pc(32'h0000_0010);
        run(mk_i(6'd4, 16'h8000), 32'd7, 32'd7, 1'b0, "R5 wrap low");
        set_pc(32'hFFFF_FFF0);
        run(mk_i(6'd5, 16'h7FFF), 32'd1, 32'd2, 1'b0, "R5 wrap high");

        // R6 and R7: every region, a few jump indices.
        for (int r = 0; r < 16; r++) begin
            set_pc({4'(r), 28'h0AB_CDE0});
            run(mk_j(6'd2, 26'h3FF_FFFF - 26'(r * 977)), 32'd0, 32'd0, 1'b0, "R6 jump");
            set_pc({4'(r), 28'h123_4560});
            run(mk_j(6'd3, 26'(r * 4099)), 32'd0, 32'd0, 1'b0, "R7 jal");
        end

        // R8 and R9: all low-bit patterns, then an aligned follow-up.
        for (int lb = 0; lb < 4; lb++) begin
            run(mk_r(6'd8), {30'h1234_5678, 2'(lb)}, 32'd0, 1'b0, "R8 jreg");
            run(mk_i(6'd8, 16'd0), 32'd0, 32'd0, 1'b0, "R9 after");
        end
        run(mk_r(6'd8), 32'h0000_0203, 32'd0, 1'b0, "R9 back to back a");
        run(mk_r(6'd8), 32'h0000_0301, 32'd0, 1'b0, "R9 back to back b");

        // R10: stalled jump, link, branch and bad register jump.
        set_pc(32'h0040_0000);
        run(mk_j(6'd2, 26'h100), 32'd0, 32'd0, 1'b1, "R10 stall j");
        run(mk_j(6'd3, 26'h100), 32'd0, 32'd0, 1'b1, "R10 stall jal");
        run(mk_i(6'd4, 16'h0010), 32'd3, 32'd3, 1'b1, "R10 stall beq");
        run(mk_r(6'd8), 32'h0000_0777, 32'd0, 1'b1, "R10 stall jreg");
        run(mk_i(6'd9, 16'd0), 32'd0, 32'd0, 1'b0, "R10 release");

        // R1: reset in mid-run.
        set_pc(32'h7654_3210);
        rst_n = 1'b0;
        instr = mk_r(6'd8); rs_val = 32'h0000_0005;
        @(posedge clk);
        @(negedge clk);
        check("R1 mid reset pc", pc, 32'h0);
        check("R1 mid reset misalign", {31'd0, misalign}, 32'd0);
        rst_n = 1'b1;
        m_pc = 32'h0;
        run(mk_i(6'd8, 16'd0), 32'd0, 32'd0, 1'b0, "R2 after reset");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule